// File: doc/BRIEF.md
# USB Endpoint Token Responder

This block decides how a single unidirectional USB function endpoint answers a token that has already been decoded. When a token arrives, it compares the token's device address and endpoint number with the endpoint's configuration byte and the device address. It then chooses one of four handshakes: none, ACK, NAK or STALL. It also decides whether the endpoint should send data from its transmit FIFO or take data into its receive FIFO. That choice depends on the FIFO readiness flags and on the enable, isochronous and stall bits of the configuration.

A decoded token is presented as a single-cycle strobe `tok_valid`, together with its kind, address and endpoint number. The decision appears exactly one clock later as a one-cycle pulse on `dec_valid`, with the result fields beside it. There is no ready signal on either side. A token can be accepted in every cycle, so tokens on consecutive cycles yield decisions on consecutive cycles. The consumer must take each decision in the cycle it is shown. Outside the pulse, every result output is held at zero.

Configuration byte `ep_cfg`: bits 3:0 are the endpoint number, bit 4 is the endpoint enable, bit 5 is the isochronous flag, bit 6 is reserved and ignored, and bit 7 is stall. Token kind encoding: 00 = OUT, 01 = IN, 10 = SETUP, 11 = reserved. Handshake encoding on `dec_hs`: 00 = none, 01 = ACK, 10 = NAK, 11 = STALL.

Top module: `usb_ep_responder`

## Requirements
- R1: After reset, `dec_valid`, `dec_match`, `dec_send`, `dec_accept` are 0 and `dec_hs` is 00 (none).
- R2: `dec_valid` is high in exactly the cycle after each cycle with `tok_valid` high, and low otherwise. Outside that pulse all result outputs are 0.
- R3: A token matches only if all of the following hold: the endpoint enable (bit 4) is set, `tok_ep` equals `ep_cfg[3:0]`, `tok_addr` equals `dev_addr`, and the kind is not reserved (11). A token that does not match gives `dec_match`=0, handshake 00 and neither send nor accept.
- R4: With `addr_cmp_en` low, no token matches, whatever the endpoint enable and the other bits hold.
- R5: A matching IN token, with the transmit FIFO enabled and not empty and stall clear, gives `dec_send`=1 and handshake 00. The host acknowledges this data.
- R6: A matching IN token in non-isochronous mode, with the transmit FIFO enabled but empty and stall clear, gives NAK (10) and no send.
- R7: A matching OUT token in non-isochronous mode, with the receive FIFO enabled and not full and stall clear, gives `dec_accept`=1 and ACK (01).
- R8: A matching OUT token in non-isochronous mode, with the receive FIFO full and stall clear, gives NAK (10) and no accept.
- R9: With stall (bit 7) set, a matching IN token with the transmit FIFO enabled, or a matching OUT token with the receive FIFO enabled, gives STALL (11) with neither send nor accept.
- R10: A SETUP token never gets STALL. It is answered as if stall were clear: ACK with accept when the receive FIFO has room, NAK when it is full.
- R11: In isochronous mode NAK and ACK are never given. An empty transmit FIFO on IN, or a full receive FIFO on OUT, gives handshake 00 with no data movement. An isochronous OUT with room gives accept with handshake 00.
- R12: A matching token whose FIFO for that direction is not enabled (transmit FIFO for IN, receive FIFO for OUT/SETUP) gives `dec_match`=1 with handshake 00 and no data movement.
- R13: Reserved configuration bit 6 has no effect on any decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tok_valid | input | 1 | Decoded token strobe, one cycle per token |
| tok_kind | input | 2 | Token kind: 00 OUT, 01 IN, 10 SETUP, 11 reserved |
| tok_addr | input | 7 | Device address carried by the token |
| tok_ep | input | 4 | Endpoint number carried by the token |
| dev_addr | input | 7 | Device address assigned to this function |
| addr_cmp_en | input | 1 | Global address-compare enable |
| ep_cfg | input | 8 | Endpoint configuration byte (fields as above) |
| tx_fifo_en | input | 1 | Transmit FIFO enabled |
| tx_fifo_empty | input | 1 | Transmit FIFO holds no data |
| rx_fifo_en | input | 1 | Receive FIFO enabled |
| rx_fifo_full | input | 1 | Receive FIFO has no room |
| dec_valid | output | 1 | Decision pulse, one cycle after the token |
| dec_match | output | 1 | Token addressed this endpoint |
| dec_hs | output | 2 | Handshake: 00 none, 01 ACK, 10 NAK, 11 STALL |
| dec_send | output | 1 | Send a data packet from the transmit FIFO |
| dec_accept | output | 1 | Take the data packet into the receive FIFO |

## Verification
Every result is due one clock after its token. Inputs are driven on a falling edge with `tok_valid` high for one cycle. The rising edge that follows registers the decision, and the checks read it at the next falling edge, one full cycle after the token was presented. The bench then holds `tok_valid` low and samples again one cycle later to confirm that the pulse has ended and the result outputs have returned to zero. A back-to-back pair of tokens checks that each decision appears in its own cycle, without merging with the other or slipping a cycle.

// File: rtl/ep_resp_pkg.sv
package ep_resp_pkg;

  localparam int unsigned ADDR_W = 7;
  localparam int unsigned EP_W   = 4;

  typedef enum logic [1:0] {
    TOK_OUT   = 2'b00,
    TOK_IN    = 2'b01,
    TOK_SETUP = 2'b10,
    TOK_RSVD  = 2'b11
  } tok_kind_e;

  typedef enum logic [1:0] {
    HS_NONE  = 2'b00,
    HS_ACK   = 2'b01,
    HS_NAK   = 2'b10,
    HS_STALL = 2'b11
  } hs_e;

  // Endpoint configuration byte, MSB first.
  typedef struct packed {
    logic            stall;
    logic            rsvd;
    logic            iso;
    logic            enable;
    logic [EP_W-1:0] epnum;
  } ep_cfg_t;

  typedef struct packed {
    logic match;
    hs_e  hs;
    logic send;
    logic accept;
  } decision_t;

endpackage

// File: rtl/ep_tok_match.sv
module ep_tok_match #(
  parameter int unsigned ADDR_W = 7,
  parameter int unsigned EP_W   = 4
) (
  input  logic [ADDR_W-1:0] tok_addr,
  input  logic [EP_W-1:0]   tok_ep,
  input  logic [ADDR_W-1:0] dev_addr,
  input  logic [EP_W-1:0]   cfg_ep,
  input  logic              cfg_enable,
  input  logic              addr_cmp_en,
  input  logic              kind_legal,
  output logic              hit
);

  logic [ADDR_W-1:0] addr_eq_bits;
  logic [EP_W-1:0]   ep_eq_bits;

  for (genvar i = 0; i < ADDR_W; i++) begin : g_addr_eq
    assign addr_eq_bits[i] = ~(tok_addr[i] ^ dev_addr[i]);
  end

  for (genvar j = 0; j < EP_W; j++) begin : g_ep_eq
    assign ep_eq_bits[j] = ~(tok_ep[j] ^ cfg_ep[j]);
  end

  assign hit = addr_cmp_en & cfg_enable & kind_legal &
               (&addr_eq_bits) & (&ep_eq_bits);

endmodule

// File: rtl/ep_hs_decide.sv
module ep_hs_decide
  import ep_resp_pkg::*;
(
  input  logic      hit,
  input  tok_kind_e kind,
  input  logic      iso,
  input  logic      stall,
  input  logic      tx_en,
  input  logic      tx_empty,
  input  logic      rx_en,
  input  logic      rx_full,
  output decision_t dec
);

  always_comb begin
    dec        = '0;
    dec.match  = hit;
    dec.hs     = HS_NONE;
    if (hit) begin
      unique case (kind)
        TOK_IN: begin
          if (tx_en) begin
            if (stall)          dec.hs = HS_STALL;
            else if (tx_empty)  dec.hs = iso ? HS_NONE : HS_NAK;
            else                dec.send = 1'b1;
          end
        end
        TOK_OUT: begin
          if (rx_en) begin
            if (stall)          dec.hs = HS_STALL;
            else if (rx_full)   dec.hs = iso ? HS_NONE : HS_NAK;
            else begin
              dec.accept = 1'b1;
              dec.hs     = iso ? HS_NONE : HS_ACK;
            end
          end
        end
        TOK_SETUP: begin
          // stall deliberately not consulted for SETUP
          if (rx_en) begin
            if (rx_full)        dec.hs = iso ? HS_NONE : HS_NAK;
            else begin
              dec.accept = 1'b1;
              dec.hs     = iso ? HS_NONE : HS_ACK;
            end
          end
        end
        default: dec = '0;
      endcase
    end
  end

endmodule

// File: rtl/usb_ep_responder.sv
module usb_ep_responder
  import ep_resp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tok_valid,
  input  logic [1:0] tok_kind,
  input  logic [6:0] tok_addr,
  input  logic [3:0] tok_ep,
  input  logic [6:0] dev_addr,
  input  logic       addr_cmp_en,
  input  logic [7:0] ep_cfg,
  input  logic       tx_fifo_en,
  input  logic       tx_fifo_empty,
  input  logic       rx_fifo_en,
  input  logic       rx_fifo_full,
  output logic       dec_valid,
  output logic       dec_match,
  output logic [1:0] dec_hs,
  output logic       dec_send,
  output logic       dec_accept
);

  ep_cfg_t   cfg;
  tok_kind_e kind;
  logic      kind_legal;
  logic      hit;
  decision_t dec_d;
  decision_t dec_q;
  logic      valid_q;
  logic      unused_rsvd;

  assign cfg         = ep_cfg_t'(ep_cfg);
  assign kind        = tok_kind_e'(tok_kind);
  assign kind_legal  = (kind != TOK_RSVD);
  assign unused_rsvd = cfg.rsvd;

  ep_tok_match #(
    .ADDR_W (ADDR_W),
    .EP_W   (EP_W)
  ) i_match (
    .tok_addr    (tok_addr),
    .tok_ep      (tok_ep),
    .dev_addr    (dev_addr),
    .cfg_ep      (cfg.epnum),
    .cfg_enable  (cfg.enable),
    .addr_cmp_en (addr_cmp_en),
    .kind_legal  (kind_legal),
    .hit         (hit)
  );

  ep_hs_decide i_decide (
    .hit      (hit),
    .kind     (kind),
    .iso      (cfg.iso),
    .stall    (cfg.stall),
    .tx_en    (tx_fifo_en),
    .tx_empty (tx_fifo_empty),
    .rx_en    (rx_fifo_en),
    .rx_full  (rx_fifo_full),
    .dec      (dec_d)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      dec_q   <= '0;
    end else begin
      valid_q <= tok_valid;
      dec_q   <= tok_valid ? dec_d : '0;
    end
  end

  assign dec_valid  = valid_q;
  assign dec_match  = dec_q.match;
  assign dec_hs     = dec_q.hs;
  assign dec_send   = dec_q.send;
  assign dec_accept = dec_q.accept;

endmodule

// File: rtl/usb_ep_responder_chk.sv
module usb_ep_responder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tok_valid,
  input logic [1:0] tok_kind,
  input logic [6:0] tok_addr,
  input logic [3:0] tok_ep,
  input logic [6:0] dev_addr,
  input logic       addr_cmp_en,
  input logic [7:0] ep_cfg,
  input logic       tx_fifo_en,
  input logic       tx_fifo_empty,
  input logic       rx_fifo_en,
  input logic       rx_fifo_full,
  input logic       dec_valid,
  input logic       dec_match,
  input logic [1:0] dec_hs,
  input logic       dec_send,
  input logic       dec_accept
);

  AST_VALID_FOLLOWS_TOKEN: assert property (@(posedge clk) disable iff (!rst_n)
    tok_valid |=> dec_valid); // R2

  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !tok_valid |=> !dec_valid); // R2

  AST_QUIET_OUTSIDE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |-> (!dec_match && dec_hs == 2'b00 && !dec_send && !dec_accept)); // R2

  AST_MISS_IS_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && !dec_match) |-> (dec_hs == 2'b00 && !dec_send && !dec_accept)); // R3

  AST_GLOBAL_OFF_NO_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_valid && !addr_cmp_en) |=> !dec_match); // R4

  AST_SEND_ACCEPT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(dec_send && dec_accept)); // R5

  AST_STALL_MOVES_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_hs == 2'b11) |-> (!dec_send && !dec_accept)); // R9

  AST_SETUP_NEVER_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_valid && tok_kind == 2'b10) |=> (dec_hs != 2'b11)); // R10

  AST_ISO_NO_NAK: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_valid && ep_cfg[5]) |=> (dec_hs != 2'b10 && dec_hs != 2'b01)); // R11

endmodule

bind usb_ep_responder usb_ep_responder_chk i_chk (.*);

// File: tb/test_usb_ep_responder.sv
module test_usb_ep_responder;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tok_valid;
  logic [1:0] tok_kind;
  logic [6:0] tok_addr;
  logic [3:0] tok_ep;
  logic [6:0] dev_addr;
  logic       addr_cmp_en;
  logic [7:0] ep_cfg;
  logic       tx_fifo_en, tx_fifo_empty, rx_fifo_en, rx_fifo_full;
  logic       dec_valid, dec_match, dec_send, dec_accept;
  logic [1:0] dec_hs;

  int n_vec = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  usb_ep_responder i_usb_ep_responder (.*);

  typedef struct packed {
    logic [1:0] kind;
    logic [6:0] addr;
    logic [3:0] ep;
    logic       cmp;
    logic [7:0] cfg;
    logic       txen, txemp, rxen, rxfull;
    logic       m;
    logic [1:0] hs;
    logic       snd, acc;
    logic [7:0] req;
  } vec_t;

  localparam int NV = 18;
  // device address 2A, configured endpoint 5
  localparam vec_t VECS [NV] = '{
    '{2'd1, 7'h2A, 4'h5, 1'b1, 8'h15, 1'b1,1'b0,1'b1,1'b0, 1'b1,2'd0,1'b1,1'b0, 8'd5},  // R5 IN data
    '{2'd1, 7'h2A, 4'h5, 1'b1, 8'h15, 1'b1,1'b1,1'b1,1'b0, 1'b1,2'd2,1'b0,1'b0, 8'd6},  // R6 IN empty
    '{2'd0, 7'h2A, 4'h5, 1'b1, 8'h15, 1'b1,1'b0,1'b1,1'b0, 1'b1,2'd1,1'b0,1'b1, 8'd7},  // R7 OUT room
    '{2'd0, 7'h2A, 4'h5, 1'b1, 8'h15, 1'b1,1'b0,1'b1,1'b1, 1'b1,2'd2,1'b0,1'b0, 8'd8},  // R8 OUT full
    '{2'd1, 7'h2A, 4'h5, 1'b1, 8'h95, 1'b1,1'b0,1'b1,1'b0, 1'b1,2'd3,1'b0,1'b0, 8'd9},  // R9 IN stall
    '{2'd0, 7'h2A, 4'h5, 1'b1, 8'h95, 1'b1,1'b0,1'b1,1'b0, 1'b1,2'd3,1'b0,1'b0, 8'd9},  // R9 OUT stall
    '{2'd2, 7'h2A, 4'h5, 1'b1, 8'h95, 1'b1,1'b0,1'b1,1'b0, 1'b1,2'd1,1'b0,1'b1, 8'd10}, // R10 SETUP room
    '{2'd2, 7'h2A, 4'h5, 1'b1, 8'h95, 1'b1,1'b0,1'b1,1'b1, 1'b1,2'd2,1'b0,1'b0, 8'd10}, // R10 SETUP full
    '{2'd1, 7'h2A, 4'h5, 1'b1, 8'h35, 1'b1,1'b1,1'b1,1'b0, 1'b1,2'd0,1'b0,1'b0, 8'd11}, // R11 iso IN empty
    '{2'd0, 7'h2A, 4'h5, 1'b1, 8'h35, 1'b1,1'b0,1'b1,1'b1, 1'b1,2'd0,1'b0,1'b0, 8'd11}, // R11 iso OUT full
    '{2'd0, 7'h2A, 4'h5, 1'b1, 8'h35, 1'b1,1'b0,1'b1,1'b0, 1'b1,2'd0,1'b0,1'b1, 8'd11}, // R11 iso OUT room
    '{2'd1, 7'h2B, 4'h5, 1'b1, 8'h15, 1'b1,1'b0,1'b1,1'b0, 1'b0,2'd0,1'b0,1'b0, 8'd3},  // R3 addr miss
    '{2'd0, 7'h2A, 4'h6, 1'b1, 8'h15, 1'b1,1'b0,1'b1,1'b0, 1'b0,2'd0,1'b0,1'b0, 8'd3},  // R3 ep miss
    '{2'd0, 7'h2A, 4'h5, 1'b1, 8'h05, 1'b1,1'b0,1'b1,1'b0, 1'b0,2'd0,1'b0,1'b0, 8'd3},  // R3 ep disabled
    '{2'd1, 7'h2A, 4'h5, 1'b0, 8'h95, 1'b1,1'b0,1'b1,1'b0, 1'b0,2'd0,1'b0,1'b0, 8'd4},  // R4 global off
    '{2'd1, 7'h2A, 4'h5, 1'b1, 8'h15, 1'b0,1'b1,1'b1,1'b0, 1'b1,2'd0,1'b0,1'b0, 8'd12}, // R12 tx off
    '{2'd3, 7'h2A, 4'h5, 1'b1, 8'h15, 1'b1,1'b0,1'b1,1'b0, 1'b0,2'd0,1'b0,1'b0, 8'd12}, // R12 rsvd kind
    '{2'd1, 7'h2A, 4'h5, 1'b1, 8'h55, 1'b1,1'b0,1'b1,1'b0, 1'b1,2'd0,1'b1,1'b0, 8'd13}  // R13 rsvd bit
  };

  task automatic check_out(input logic v, input logic m, input logic [1:0] hs,
                           input logic s, input logic a, input int req);
    n_vec++;
    if ({dec_valid, dec_match, dec_hs, dec_send, dec_accept} !== {v, m, hs, s, a}) begin
      n_bad++;
      $display("FAIL R%0d: got v=%b m=%b hs=%b s=%b a=%b, want v=%b m=%b hs=%b s=%b a=%b",
               req, dec_valid, dec_match, dec_hs, dec_send, dec_accept, v, m, hs, s, a);
    end
  endtask

  task automatic drive(input vec_t t);
    tok_valid   = 1'b1;
    tok_kind    = t.kind;
    tok_addr    = t.addr;
    tok_ep      = t.ep;
    addr_cmp_en = t.cmp;
    ep_cfg      = t.cfg;
    tx_fifo_en  = t.txen;  tx_fifo_empty = t.txemp;
    rx_fifo_en  = t.rxen;  rx_fifo_full  = t.rxfull;
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog: got timeout, want completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; tok_valid = 1'b0; tok_kind = 2'd0; tok_addr = 7'h2A; tok_ep = 4'h5;
    dev_addr = 7'h2A; addr_cmp_en = 1'b1; ep_cfg = 8'h15;
    tx_fifo_en = 1'b1; tx_fifo_empty = 1'b0; rx_fifo_en = 1'b1; rx_fifo_full = 1'b0;
    repeat (3) @(negedge clk);
    check_out(1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1); // R1 reset state
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VECS[i]);
      @(negedge clk);
      tok_valid = 1'b0;
      check_out(1'b1, VECS[i].m, VECS[i].hs, VECS[i].snd, VECS[i].acc, int'(VECS[i].req));
      @(negedge clk);
      check_out(1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 2); // R2 pulse ends, outputs cleared
    end

    // R2 back-to-back tokens: OUT ACK then IN NAK on consecutive cycles
    @(negedge clk);
    drive(VECS[2]);
    @(negedge clk);
    drive(VECS[1]);
    check_out(1'b1, 1'b1, 2'd1, 1'b0, 1'b1, 2);
    @(negedge clk);
    tok_valid = 1'b0;
    check_out(1'b1, 1'b1, 2'd2, 1'b0, 1'b0, 2);
    @(negedge clk);
    check_out(1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 2);

    // R2 idle inputs that would match produce no decision
    repeat (3) @(negedge clk);
    check_out(1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 2);

    // R1 reset in the middle of a token clears the pending decision
    drive(VECS[0]);
    rst_n = 1'b0;
    @(negedge clk);
    tok_valid = 1'b0;
    check_out(1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1);
    rst_n = 1'b1;
    @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule